// File: doc/BRIEF.md
# Page translation register bank

This block holds a small set of page-mapping registers for an 8-bit processor with a 16-bit address bus. The processor's 64 KB space is split into sixteen 4 KB pages. Each page has one 8-bit register, and that register names the physical page the processor reaches through it. The lower six bits of the selected register, placed above the untouched 12-bit page offset, form an 18-bit physical address that reaches 256 KB of RAM. The low four bits of the same value also mark the high (ROM) region and the I/O region for the system's region decoder.

Software loads the bank by writing into the top sixteen bytes of memory. The low four address bits of that write pick the register. The bank cannot be read back. At all other times the top four processor address bits index the bank with no clock in between, so a translated address is ready in the same cycle as the processor address. After reset every page maps to itself, so boot code runs before any remap.

Top module: `pmap_bank`

## Requirements
- R1: After reset, register n holds the value n for every n from 0 to 15, so every page translates to itself (page_o equals {4'h0, addr_i[15:12]}).
- R2: A write occurs on a rising clock edge when sel_i=1, rd_nwr_i=0, vma_i=1 and addr_i is in 16'hFFF0..16'hFFFF. addr_i[3:0] selects the register, and from the following cycle the register holds wdata_i.
- R3: No register changes when any write condition is missing. The cases are sel_i=0, rd_nwr_i=1, vma_i=0, or an address outside the top-sixteen window (for example 16'hFF05 or 16'h1FF3).
- R4: phys_addr_o equals {page_o[5:0], addr_i[11:0]}.
- R5: The lookup is combinational. page_o shows the register indexed by addr_i[15:12] in the same cycle that addr_i changes.
- R6: hi_region_o is 1 exactly when page_o[3:0]=4'hF. io_region_o is 1 exactly when page_o[3:0]=4'hE. Any other value gives 0 on both.
- R7: Bits 7:6 of each register are stored as written and return unchanged on page_o[7:6].
- R8: A write changes only the register it selects. The other fifteen keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Chip select for the bank |
| rd_nwr_i | input | 1 | 1 = read cycle, 0 = write cycle |
| vma_i | input | 1 | Processor address is valid this cycle |
| addr_i | input | 16 | Processor address |
| wdata_i | input | 8 | Write data |
| page_o | output | 8 | Translated page value for addr_i[15:12] |
| phys_addr_o | output | 18 | Physical RAM address |
| hi_region_o | output | 1 | Translated page is in the high region |
| io_region_o | output | 1 | Translated page is in the I/O region |

## Verification
All sixteen pages are swept after reset to confirm the identity map. The same sweep runs after a full remap with distinct values. A reversed map with high bits set tells an index-select error apart from a data error, and it also exposes lost bits 7:6. Single writes to one register, each missing one enable or landing just outside the window, separate a correct write gate from a partial one. The full sweep after each of these shows that no neighbour was disturbed. Values ending in E, F and others drive the region flags.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  typedef enum logic [1:0] {
    RGN_RAM = 2'd0,
    RGN_IO  = 2'd1,
    RGN_HI  = 2'd2
  } region_e;

  function automatic region_e region_of(input logic [3:0] tag);
    case (tag)
      4'hF:    return RGN_HI;
      4'hE:    return RGN_IO;
      default: return RGN_RAM;
    endcase
  endfunction
endpackage

// File: rtl/pmap_wr_dec.sv
module pmap_wr_dec #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  localparam int NUM   = 1 << IDX_W
) (
  input  logic              sel_i,
  input  logic              rd_nwr_i,
  input  logic              vma_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM-1:0]    wr_o
);
  logic in_win;
  assign in_win = &addr_i[ADDR_W-1:IDX_W];

  always_comb begin
    wr_o = '0;
    if (sel_i && !rd_nwr_i && vma_i && in_win)
      wr_o[addr_i[IDX_W-1:0]] = 1'b1;
  end
endmodule

// File: rtl/pmap_regs.sv
module pmap_regs #(
  parameter int IDX_W  = 4,
  parameter int PAGE_W = 8,
  localparam int NUM   = 1 << IDX_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM-1:0]             wr_i,
  input  logic [PAGE_W-1:0]          wdata_i,
  output logic [NUM-1:0][PAGE_W-1:0] regs_o
);
  for (genvar n = 0; n < NUM; n++) begin : g_reg
    // identity map out of reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     regs_o[n] <= PAGE_W'(n);
      else if (wr_i[n]) regs_o[n] <= wdata_i;
    end
  end
endmodule

// File: rtl/pmap_lookup.sv
module pmap_lookup
  import pmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int PAGE_W = 8,
  parameter int PHYS_W = 18,
  localparam int NUM   = 1 << IDX_W,
  localparam int OFF_W = ADDR_W - IDX_W,
  localparam int HI_W  = PHYS_W - OFF_W
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM-1:0][PAGE_W-1:0] regs_i,
  output logic [PAGE_W-1:0]          page_o,
  output logic [PHYS_W-1:0]          phys_addr_o,
  output logic                       hi_region_o,
  output logic                       io_region_o
);
  region_e rgn;

  assign page_o      = regs_i[addr_i[ADDR_W-1:OFF_W]];
  assign phys_addr_o = {page_o[HI_W-1:0], addr_i[OFF_W-1:0]};
  assign rgn         = region_of(page_o[3:0]);
  assign hi_region_o = (rgn == RGN_HI);
  assign io_region_o = (rgn == RGN_IO);
endmodule

// File: rtl/pmap_bank.sv
module pmap_bank #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int PAGE_W = 8,
  parameter int PHYS_W = 18,
  localparam int NUM   = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_nwr_i,
  input  logic              vma_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PAGE_W-1:0] wdata_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [PHYS_W-1:0] phys_addr_o,
  output logic              hi_region_o,
  output logic              io_region_o
);
  logic [NUM-1:0]             wr;
  logic [NUM-1:0][PAGE_W-1:0] regs;

  pmap_wr_dec #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .sel_i(sel_i), .rd_nwr_i(rd_nwr_i), .vma_i(vma_i), .addr_i(addr_i), .wr_o(wr)
  );

  pmap_regs #(.IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wdata_i(wdata_i), .regs_o(regs)
  );

  pmap_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W)) u_lut (
    .addr_i(addr_i), .regs_i(regs), .page_o(page_o), .phys_addr_o(phys_addr_o),
    .hi_region_o(hi_region_o), .io_region_o(io_region_o)
  );
endmodule

// File: rtl/pmap_bank_chk.sv
module pmap_bank_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int PAGE_W = 8,
  parameter int PHYS_W = 18,
  localparam int OFF_W = ADDR_W - IDX_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_any,
  input logic [ADDR_W-1:0] addr_i,
  input logic [PAGE_W-1:0] wdata_i,
  input logic [PAGE_W-1:0] page_o,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic              hi_region_o,
  input logic              io_region_o
);
  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> (addr_i[ADDR_W-1:OFF_W] != $past(addr_i[IDX_W-1:0])) ||
               (page_o == $past(wdata_i)));

  // R3, R8: without a write the looked-up entry cannot move
  p_hold_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> (!$stable(addr_i[ADDR_W-1:OFF_W]) || $stable(page_o)));

  p_offset_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phys_addr_o[OFF_W-1:0] == addr_i[OFF_W-1:0]);

  p_hi_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_region_o |-> (page_o[3:0] == 4'hF));

  p_io_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_region_o |-> (page_o[3:0] == 4'hE));

  p_flags_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hi_region_o, io_region_o}));
endmodule

bind pmap_bank pmap_bank_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_any(|wr), .addr_i(addr_i), .wdata_i(wdata_i),
  .page_o(page_o), .phys_addr_o(phys_addr_o),
  .hi_region_o(hi_region_o), .io_region_o(io_region_o)
);

// File: tb/sim_pmap_bank.sv
module sim_pmap_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0;
  logic        rd_nwr_i = 1'b1;
  logic        vma_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  page_o;
  logic [17:0] phys_addr_o;
  logic        hi_region_o, io_region_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_map [16];

  always #10 clk_i = ~clk_i;

  pmap_bank u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // full sweep of all pages against the model
  task automatic sweep(input string req);
    for (int p = 0; p < 16; p++) begin
      @(negedge clk_i);
      addr_i = {p[3:0], 12'h5A3};
      #1;
      chk(req, page_o, exp_map[p]);
      chk("R4", phys_addr_o, {exp_map[p][5:0], 12'h5A3});
      chk("R6", {hi_region_o, io_region_o},
          {exp_map[p][3:0] == 4'hF, exp_map[p][3:0] == 4'hE});
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d,
                        input logic s, input logic rw, input logic v);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; sel_i = s; rd_nwr_i = rw; vma_i = v;
    @(negedge clk_i);
    sel_i = 1'b0; rd_nwr_i = 1'b1; vma_i = 1'b0;
    if (s && !rw && v && a[15:4] == 12'hFFF) exp_map[a[3:0]] = d;
  endtask

  task automatic t_reset;
    for (int p = 0; p < 16; p++) exp_map[p] = 8'(p);
    sweep("R1");
  endtask

  task automatic t_remap_all;
    // reversed map, high bits set
    for (int p = 0; p < 16; p++) bus_wr(16'hFFF0 | 16'(p), {2'b11, 2'b00, 4'(15 - p)} ^ 8'h30, 1, 0, 1);
    sweep("R2");
  endtask

  task automatic t_ignored;
    bus_wr(16'hFFF3, 8'h77, 0, 0, 1);
    bus_wr(16'hFFF3, 8'h77, 1, 1, 1);
    bus_wr(16'hFFF3, 8'h77, 1, 0, 0);
    bus_wr(16'hFF05, 8'h77, 1, 0, 1);
    bus_wr(16'h1FF3, 8'h77, 1, 0, 1);
    sweep("R3");
  endtask

  task automatic t_single;
    bus_wr(16'hFFF9, 8'hA5, 1, 0, 1);
    sweep("R8");
  endtask

  task automatic t_comb;
    bus_wr(16'hFFF2, 8'h1E, 1, 0, 1);
    bus_wr(16'hFFF6, 8'h2F, 1, 0, 1);
    @(negedge clk_i);
    addr_i = 16'h2000; #1;
    chk("R5", page_o, 8'h1E);
    chk("R6", {hi_region_o, io_region_o}, 2'b01);
    addr_i = 16'h6FFF; #1;
    chk("R5", page_o, 8'h2F);
    chk("R6", {hi_region_o, io_region_o}, 2'b10);
    chk("R4", phys_addr_o, 18'h2FFFF);
  endtask

  task automatic t_top_bits;
    bus_wr(16'hFFF4, 8'h81, 1, 0, 1);
    bus_wr(16'hFFF5, 8'h42, 1, 0, 1);
    @(negedge clk_i);
    addr_i = 16'h4000; #1;
    chk("R7", page_o[7:6], 2'b10);
    addr_i = 16'h5000; #1;
    chk("R7", page_o[7:6], 2'b01);
    chk("R7", phys_addr_o[17:12], 6'h02);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_remap_all();
    t_ignored();
    t_single();
    t_comb();
    t_top_bits();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule